// File: doc/BRIEF.md
# MDIO Watchdog and Boot-Mode Controller

This block is a management slave on a two-wire MDIO bus. It serves a small board controller that supervises a host FPGA. It decodes standard read and write frames that carry its own station address. Through a handful of 16-bit registers it lets software do three things: arm a watchdog in one of two clocking modes, read back the watchdog and restart state, and request a soft reset of the host with a chosen 2-bit boot mode.

The MDC and MDIO lines are oversampled in the system clock domain. Write frames and frames for other stations leave the data line released. Read frames drive a zero in the second turnaround bit and then 16 data bits, most significant bit first.

The watchdog counts either system clock cycles or rising edges of a clock supplied by the FPGA fabric. A kick input clears the count. A timeout fires the same fixed-length, active-low host reset pulse that a software reset command fires. The boot mode presented to the host comes from the control register until the first commanded reset. From then on it comes from a copy latched when that reset ended.

Top module: `mdio_wdt_boot`

## Requirements
- R1: Frames whose 5-bit station address differs from PHY_ADDR (default 0x1A) never drive MDIO and change no register.
- R2: On a read frame with a matching address, the block asserts mdio_oe only in the second turnaround bit, where it drives 0, and during the 16 data bits, sent MSB first. It releases mdio_oe after the last data bit.
- R3: Frames use opcode 01 for write and 10 for read, and a write frame never asserts mdio_oe.
- R4: A read of register 4 returns the REVISION parameter.
- R5: A read of register 5 returns {watchdog status[1:0], 3'b000, restarted, latched boot[1:0], 8'h00}. All other registers read 0.
- R6: Writing 0xA500 to register 7 arms the system-clock watchdog (status 10). Writing 0xB600 arms the fabric-clock watchdog: status 01 when wd_chip_present is 1, and status 11 when it is 0. Any other value written to register 7 leaves the status unchanged.
- R7: With status 10, 2^WDT_BITS system clock cycles without a kick produce a host reset pulse, and the status returns to 00.
- R8: With status 01 or 11, the count advances once per rising edge of fab_clk, and a timeout occurs after 2^WDT_BITS such edges.
- R9: A wd_kick pulse restarts the watchdog count, so periodic kicks prevent any reset.
- R10: While no commanded reset has completed, boot_mode equals register 4 bits 9:8. Writing register 4 with bits 15:12 equal to 0xA produces one host_rst_n low pulse of exactly RST_CYCLES cycles. Any other value in bits 15:12 produces no pulse. After reset, host_rst_n is 1 and boot_mode is 0.
- R11: At the end of a commanded pulse, the restarted flag is set and register 4 bits 9:8 are latched. From then on boot_mode follows the latched value, and later writes to register 4 bits 9:8 alone do not change it. The command field clears, so one command yields one pulse.
- R12: A pulse caused by a watchdog timeout does not set the restarted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock, oversampled |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | Tristate enable for mdio_o |
| fab_clk | input | 1 | Clock from the FPGA fabric for the fabric-clock watchdog modes |
| wd_chip_present | input | 1 | Strap, 1 when an external watchdog device is fitted |
| wd_kick | input | 1 | Watchdog service pulse in the clk domain |
| host_rst_n | output | 1 | Active-low reset to the host FPGA |
| boot_mode | output | 2 | Boot mode presented to the host |

## Verification
The bench sends frames to random foreign addresses, including ones that carry the reset command. A decoder that ignored the address would then pulse the host or drive the line. It checks the line-enable pattern bit by bit, which catches an off-by-one turnaround that would clash with the master or drop the data MSB. It measures timeout latency separately in the system-clock and fabric-clock modes, so that swapped clock selection or a miscounted limit falls outside the window. It also checks that a commanded reset fires once, that it latches the boot mode and holds it against later writes, and that a watchdog reset leaves the restarted flag clear.

// File: rtl/mdio_wdt_boot.sv
module mdio_wdt_boot #(
  parameter logic [4:0]  PHY_ADDR   = 5'h1A,
  parameter logic [15:0] REVISION   = 16'h0006,
  parameter int          WDT_BITS   = 20,
  parameter int          RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       fab_clk,
  input  logic       wd_chip_present,
  input  logic       wd_kick,
  output logic       host_rst_n,
  output logic [1:0] boot_mode
);
  localparam int          PW      = $clog2(RST_CYCLES + 1);
  localparam logic [15:0] ARM_SW  = 16'hA500;
  localparam logic [15:0] ARM_HW  = 16'hB600;
  localparam logic [3:0]  CMD_RST = 4'hA;

  typedef enum logic [1:0] {S_PRE, S_HDR, S_TA, S_DAT} st_t;

  logic [2:0] mdc_s, fab_s;
  logic [1:0] mdio_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_s  <= '0;
      fab_s  <= '0;
      mdio_s <= '1;
    end else begin
      mdc_s  <= {mdc_s[1:0], mdc};
      fab_s  <= {fab_s[1:0], fab_clk};
      mdio_s <= {mdio_s[0], mdio_i};
    end
  end

  wire mdc_rise = mdc_s[1] & ~mdc_s[2];
  wire fab_rise = fab_s[1] & ~fab_s[2];
  wire bit_in   = mdio_s[1];

  st_t         st;
  logic [5:0]  ones;
  logic [4:0]  cnt;
  logic [11:0] hdr;
  logic        rd_frame;
  logic [4:0]  reg_a;
  logic [15:0] sh, rd_val, wr_data;
  logic        wr_stb;

  logic [1:0]          wmode;
  logic [WDT_BITS-1:0] wcnt;
  logic [3:0]          ctl_cmd;
  logic [1:0]          ctl_boot, boot_after;
  logic                restarted, by_cmd;
  logic [PW-1:0]       pcnt;

  wire [12:0] hdr_full = {hdr, bit_in};
  wire hdr_ok = hdr_full[12] && (hdr_full[9:5] == PHY_ADDR) &&
                (hdr_full[11:10] == 2'b10 || hdr_full[11:10] == 2'b01);
  wire [15:0] stat5 = {wmode, 3'b000, restarted, boot_after, 8'h00};

  always_comb begin
    case (hdr_full[4:0])
      5'd4:    rd_val = REVISION;
      5'd5:    rd_val = stat5;
      default: rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PRE; ones <= '0; cnt <= '0; hdr <= '0; rd_frame <= 1'b0;
      reg_a <= '0; sh <= '0; wr_data <= '0; wr_stb <= 1'b0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (mdc_rise) begin
        case (st)
          S_PRE: begin
            if (bit_in) begin
              if (ones != 6'd32) ones <= ones + 6'd1;
            end else begin
              if (ones == 6'd32) begin
                st  <= S_HDR;
                cnt <= '0;
              end
              ones <= '0;
            end
          end
          S_HDR: begin
            hdr <= hdr_full[11:0];
            cnt <= cnt + 5'd1;
            if (cnt == 5'd12) begin
              if (hdr_ok) begin
                st       <= S_TA;
                cnt      <= '0;
                rd_frame <= (hdr_full[11:10] == 2'b10);
                reg_a    <= hdr_full[4:0];
                sh       <= rd_val;
              end else begin
                st <= S_PRE;
              end
            end
          end
          S_TA: begin
            if (cnt == 5'd0) begin
              cnt <= 5'd1;
              if (rd_frame) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              st  <= S_DAT;
              cnt <= '0;
              if (rd_frame) begin
                mdio_o <= sh[15];
                sh     <= {sh[14:0], 1'b0};
              end
            end
          end
          S_DAT: begin
            wr_data <= {wr_data[14:0], bit_in};
            cnt     <= cnt + 5'd1;
            if (cnt == 5'd15) begin
              mdio_oe  <= 1'b0;
              st       <= S_PRE;
              rd_frame <= 1'b0;
              wr_stb   <= ~rd_frame;
            end else if (rd_frame) begin
              mdio_o <= sh[15];
              sh     <= {sh[14:0], 1'b0};
            end
          end
          default: st <= S_PRE;
        endcase
      end
    end
  end

  wire tick    = (wmode == 2'b10) | ((wmode != 2'b00) & fab_rise);
  wire timeout = tick & (&wcnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmode <= 2'b00; wcnt <= '0; ctl_cmd <= '0; ctl_boot <= '0;
      boot_after <= '0; restarted <= 1'b0; by_cmd <= 1'b0;
      pcnt <= '0; host_rst_n <= 1'b1;
    end else begin
      if (wd_kick)   wcnt <= '0;
      else if (tick) wcnt <= wcnt + 1'b1;
      if (timeout)   wmode <= 2'b00;

      if (wr_stb && reg_a == 5'd7) begin
        if (wr_data == ARM_SW) begin
          wmode <= 2'b10;
          wcnt  <= '0;
        end else if (wr_data == ARM_HW) begin
          wmode <= wd_chip_present ? 2'b01 : 2'b11;
          wcnt  <= '0;
        end
      end

      if (host_rst_n) begin
        if (ctl_cmd == CMD_RST) begin
          host_rst_n <= 1'b0; pcnt <= '0; by_cmd <= 1'b1;
        end else if (timeout) begin
          host_rst_n <= 1'b0; pcnt <= '0; by_cmd <= 1'b0;
        end
      end else if (pcnt == PW'(RST_CYCLES - 1)) begin
        host_rst_n <= 1'b1;
        if (by_cmd) begin
          restarted  <= 1'b1;
          boot_after <= ctl_boot;
          ctl_cmd    <= '0;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end

      if (wr_stb && reg_a == 5'd4) begin
        ctl_cmd  <= wr_data[15:12];
        ctl_boot <= wr_data[9:8];
      end
    end
  end

  assign boot_mode = restarted ? boot_after : ctl_boot;

  assert_ta_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> (mdio_o == 1'b0));
  assert_drive_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (rd_frame && (st == S_TA || st == S_DAT)));
  assert_hw_needs_chip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wmode) && wmode == 2'b01) |-> wd_chip_present);
  assert_timeout_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_rst_n) && !by_cmd) |-> (wmode == 2'b00));
  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_n) |-> ($past(pcnt) == PW'(RST_CYCLES - 1)));
  assert_restart_after_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restarted) |-> $rose(host_rst_n));
  assert_wdt_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rst_n) && !by_cmd) |-> $stable(restarted));
endmodule

// File: tb/mdio_wdt_boot_test.sv
module mdio_wdt_boot_test;
  localparam logic [4:0]  ADDR = 5'h1A;
  localparam logic [15:0] REV  = 16'h0306;
  localparam int          WB   = 12;
  localparam int          RC   = 16;

  logic clk = 0, rst_n = 0, mdc = 0, fab_clk = 0, chip = 0, kick = 0;
  logic m_oe = 0, m_val = 1;
  logic mdio_o, mdio_oe, host_rst_n;
  logic [1:0] boot_mode;
  wire mdio_line = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

  mdio_wdt_boot #(.PHY_ADDR(ADDR), .REVISION(REV), .WDT_BITS(WB), .RST_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_line), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .fab_clk(fab_clk), .wd_chip_present(chip), .wd_kick(kick),
    .host_rst_n(host_rst_n), .boot_mode(boot_mode));

  always #2 clk = ~clk;
  always #8 fab_clk = ~fab_clk;

  int checks = 0, fails = 0, pulses = 0, low_len = 0, cur_low = 0, cyc = 0, fall_t = 0;
  bit done = 0;

  always @(negedge clk) begin
    cyc++;
    if (!host_rst_n) begin
      if (cur_low == 0) begin pulses++; fall_t = cyc; end
      cur_low++;
    end else begin
      if (cur_low != 0) low_len = cur_low;
      cur_low = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp5(input logic [1:0] w, input logic r, input logic [1:0] b);
    return {w, 3'b000, r, b, 8'h00};
  endfunction

  task automatic frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, output logic [15:0] rv, output bit pat_ok);
    logic [63:0] bits;
    bit mine;
    mine = rd && (phy == ADDR);
    bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, rd ? 2'b11 : 2'b10,
            rd ? 16'hFFFF : wd};
    pat_ok = 1; rv = '0;
    for (int i = 63; i >= 0; i--) begin
      m_oe = !(rd && i <= 17);
      m_val = bits[i];
      repeat (5) @(negedge clk);
      if (mdio_oe !== (mine && i <= 16)) pat_ok = 0;
      if (mine && i == 16 && mdio_line !== 1'b0) pat_ok = 0;
      if (i < 16) rv[i] = mdio_line;
      mdc = 1;
      repeat (5) @(negedge clk);
      mdc = 0;
    end
    m_oe = 0;
    repeat (4) @(negedge clk);
    if (mdio_oe) pat_ok = 0;
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] rv; bit ok;
    frame(0, ADDR, ra, d, rv, ok);
    check(ok, "R3 write frame left MDIO undriven", mdio_oe, 0);
  endtask

  task automatic rd(input logic [4:0] ra, output logic [15:0] v);
    bit ok;
    frame(1, ADDR, ra, 16'h0, v, ok);
    check(ok, "R2 read drive pattern", ok, 1);
  endtask

  initial begin
    logic [15:0] v, d;
    logic [4:0] p;
    logic [1:0] cur_boot;
    int t0, np;
    bit ok;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(host_rst_n === 1'b1, "R10 reset host_rst_n", host_rst_n, 1);
    check(boot_mode === 2'b00, "R10 reset boot_mode", boot_mode, 0);
    check(mdio_oe === 1'b0, "R2 reset mdio_oe", mdio_oe, 0);

    rd(5'd4, v);
    check(v == REV, "R4 revision read", v, REV);
    rd(5'd5, v);
    check(v == exp5(2'b00, 0, 2'b00), "R5 status after reset", v, exp5(2'b00, 0, 2'b00));
    rd(5'd9, v);
    check(v == 16'h0, "R5 unused register reads zero", v, 0);

    for (int k = 0; k < 5; k++) begin
      do p = 5'($urandom_range(0, 31)); while (p == ADDR);
      np = pulses;
      frame(0, p, 5'd4, 16'hA300, v, ok);
      check(ok, "R1 foreign write undriven", ok, 1);
      frame(1, p, 5'd4, 16'h0, v, ok);
      check(ok, "R1 foreign read undriven", ok, 1);
      repeat (40) @(negedge clk);
      check(pulses == np && boot_mode == 2'b00, "R1 foreign frame no effect", boot_mode, 0);
    end

    for (int k = 0; k < 5; k++) begin
      d = 16'($urandom());
      if (d[15:12] == 4'hA) d[15:12] = 4'h5;
      np = pulses;
      wr(5'd4, d);
      repeat (40) @(negedge clk);
      check(boot_mode == d[9:8], "R10 boot_mode follows reg4", boot_mode, d[9:8]);
      check(pulses == np, "R10 non-command value no pulse", pulses - np, 0);
    end
    cur_boot = boot_mode;

    d = 16'($urandom());
    if (d == 16'hA500 || d == 16'hB600) d = 16'h1234;
    wr(5'd7, d);
    rd(5'd5, v);
    check(v[15:14] == 2'b00, "R6 other reg7 value ignored", v[15:14], 0);

    chip = 1;
    wr(5'd7, 16'hB600);
    rd(5'd5, v);
    check(v == exp5(2'b01, 0, 2'b00), "R6 hw mode with chip", v, exp5(2'b01, 0, 2'b00));
    np = pulses;
    for (int k = 0; k < 8; k++) begin
      repeat (3000) @(negedge clk);
      kick = 1; @(negedge clk); kick = 0;
    end
    check(pulses == np, "R9 kicks prevent reset", pulses - np, 0);
    t0 = cyc;
    while (pulses == np && cyc - t0 < 20000) @(negedge clk);
    check(fall_t - t0 >= 16340 && fall_t - t0 <= 16420, "R8 fabric clock timeout latency",
          fall_t - t0, 16384);
    repeat (30) @(negedge clk);
    check(low_len == RC, "R10 pulse length", low_len, RC);
    rd(5'd5, v);
    check(v == exp5(2'b00, 0, 2'b00), "R12 timeout keeps restarted clear, R7 disarm", v,
          exp5(2'b00, 0, 2'b00));

    chip = 0;
    wr(5'd7, 16'hB600);
    t0 = cyc;
    np = pulses;
    rd(5'd5, v);
    check(v[15:14] == 2'b11, "R6 hw request without chip", v[15:14], 3);
    while (pulses == np && cyc - t0 < 20000) @(negedge clk);
    check(fall_t - t0 >= 16340 && fall_t - t0 <= 16420, "R8 fallback fabric timeout",
          fall_t - t0, 16384);

    repeat (40) @(negedge clk);
    wr(5'd7, 16'hA500);
    t0 = cyc;
    np = pulses;
    rd(5'd5, v);
    check(v[15:14] == 2'b10, "R6 sw mode status", v[15:14], 2);
    while (pulses == np && cyc - t0 < 8000) @(negedge clk);
    check(fall_t - t0 >= 4080 && fall_t - t0 <= 4105, "R7 system clock timeout latency",
          fall_t - t0, 4096);
    repeat (30) @(negedge clk);
    rd(5'd5, v);
    check(v[15:14] == 2'b00, "R7 status back to inactive", v[15:14], 0);
    check(boot_mode == cur_boot, "R12 boot unchanged by watchdog", boot_mode, cur_boot);

    np = pulses;
    wr(5'd4, 16'hA200);
    repeat (300) @(negedge clk);
    check(pulses == np + 1, "R10 command gives one pulse", pulses - np, 1);
    check(low_len == RC, "R10 command pulse length", low_len, RC);
    check(boot_mode == 2'b10, "R11 latched boot applied", boot_mode, 2);
    rd(5'd5, v);
    check(v == exp5(2'b00, 1, 2'b10), "R11 restarted flag and latched boot", v,
          exp5(2'b00, 1, 2'b10));
    wr(5'd4, 16'h0100);
    repeat (40) @(negedge clk);
    check(boot_mode == 2'b10, "R11 later reg4 boot ignored", boot_mode, 2);
    check(pulses == np + 1, "R11 no retrigger", pulses - np, 1);
    wr(5'd4, 16'hA300);
    repeat (300) @(negedge clk);
    check(pulses == np + 2 && boot_mode == 2'b11, "R11 second command relatches", boot_mode, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule